// File: doc/BRIEF.md
# Instruction Packet Slot Extractor

This block takes one 64-bit aligned instruction packet and splits it into as many as four instruction slots, in program order. The top four bits of the packet are a header. The upper three bits of the header pick one of five fixed mixes of 16-, 32- and 64-bit instructions. The lowest header bit is a hint that the instructions may issue in parallel. The header's own bits are not part of any instruction. The 60 bits below it hold the instruction payloads back to back. Each 16-bit unit of the packet gives 15 payload bits, so a 16-bit instruction carries 15 bits, a 32-bit one carries 30 and a 64-bit one carries 60.

A branch can land at any 16-bit position in the packet. An entry offset in 16-bit units tells the block where execution begins. Slots that start before that position are dropped. If no instruction starts exactly at the offset, the block raises a misaligned-entry flag. The front end feeds one packet per cycle, and the split result appears on registered outputs one clock later. Decode logic downstream reads each slot's valid bit, size code, start position and right-aligned payload.

Top module: `pkt_slot_extract`

## Requirements
- R1: While `rst_n` is low at a rising edge, every output is 0 after that edge. Otherwise the outputs after a rising edge reflect the `pkt_i` and `entry_i` sampled at that edge.
- R2: Format code `pkt_i[63:61]` = 000 gives one slot. Slot 0 has size code 2 (64-bit), start 0 and payload `pkt_i[59:0]`. Size codes are 0 = 16-bit, 1 = 32-bit, 2 = 64-bit. Starts count 16-bit units from the packet's top.
- R3: Format 100 gives two 32-bit slots (size code 1). Slot 0 has start 0 and payload `pkt_i[59:30]`. Slot 1 has start 2 and payload `pkt_i[29:0]`.
- R4: Format 101 gives three slots. Slot 0 is 16-bit at start 0 with payload `pkt_i[59:45]`. Slot 1 is 16-bit at start 1 with payload `pkt_i[44:30]`. Slot 2 is 32-bit at start 2 with payload `pkt_i[29:0]`.
- R5: Format 110 gives three slots. Slot 0 is 32-bit at start 0 with payload `pkt_i[59:30]`. Slot 1 is 16-bit at start 2 with payload `pkt_i[29:15]`. Slot 2 is 16-bit at start 3 with payload `pkt_i[14:0]`.
- R6: Format 111 gives four 16-bit slots at starts 0 to 3. Slot k has the payload at `pkt_i[59-15k -: 15]`.
- R7: Format codes 001, 010 and 011 raise `illegal_o`. They also clear every slot valid, `par_o` and `misalign_o`.
- R8: For a legal format, `par_o` equals header bit `pkt_i[60]`.
- R9: A slot is valid only if its format uses it and its start is at least `entry_i`.
- R10: `misalign_o` is 1 when the format is legal and no slot of that format starts exactly at `entry_i`. For example, offset 1 in format 000 raises it and leaves no slot valid.
- R11: Every slot whose valid is 0 drives 0 on its size, start and payload fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pkt_i | input | 64 | Aligned instruction packet; header in [63:60] |
| entry_i | input | 2 | Entry offset in 16-bit units |
| slot_vld_o | output | 4 | Per-slot valid; bit k is slot k |
| slot_size_o | output | 8 | Per-slot size code, slot k at [2k+1:2k] |
| slot_start_o | output | 8 | Per-slot start unit, slot k at [2k+1:2k] |
| slot_payload_o | output | 240 | Per-slot payload, right-aligned, slot k at [60k+59:60k] |
| par_o | output | 1 | Parallel hint of a legal packet |
| illegal_o | output | 1 | Reserved format code seen |
| misalign_o | output | 1 | Entry offset falls inside an instruction |

## Verification
The bench runs a directed case for every format at entry offset 0, to confirm each payload window and start position on its own. Next it tries each nonzero offset against formats whose instruction boundaries differ. This separates entries that drop leading slots from entries that land inside a 32- or 64-bit instruction. Each reserved code is applied with the parallel bit set and a nonzero offset, so a leak of the hint, a stray misalign or a stray valid would show up. Random packets and offsets then mix all formats with random payload bits. These catch any crossed window edge or wrong zeroing of an invalid slot.

// File: rtl/pkt_slot_pkg.sv
// Shared constants and types for the packet slot extractor.
// Assumes the packet width is a whole number of 16-bit units and
// that the header width equals the number of units.
package pkt_slot_pkg;
    localparam int PKT_W  = 64;
    localparam int UNIT_W = 16;
    localparam int HDR_W  = 4;
    localparam int FMT_W  = HDR_W - 1;
    localparam int NUNIT  = PKT_W / UNIT_W;
    localparam int NSLOT  = NUNIT;
    localparam int BODY_W = PKT_W - HDR_W;
    localparam int PPU    = BODY_W / NUNIT;
    localparam int POS_W  = $clog2(NUNIT);
    localparam int SZ_W   = 2;

    typedef enum logic [SZ_W-1:0] {
        SZ_HALF = 2'd0,
        SZ_WORD = 2'd1,
        SZ_DBL  = 2'd2,
        SZ_NONE = 2'd3
    } slot_sz_e;

    typedef struct packed {
        logic             used;
        slot_sz_e         sz;
        logic [POS_W-1:0] pos;
    } slot_lay_t;

    // Size of program-order slot k for a format code; SZ_NONE when unused.
    function automatic slot_sz_e fmt_slot_size(logic [FMT_W-1:0] fmt, int k);
        case (fmt)
            3'b000:  return (k == 0) ? SZ_DBL : SZ_NONE;
            3'b100:  return (k < 2) ? SZ_WORD : SZ_NONE;
            3'b101:  return (k < 2) ? SZ_HALF : ((k == 2) ? SZ_WORD : SZ_NONE);
            3'b110:  return (k == 0) ? SZ_WORD : ((k < 3) ? SZ_HALF : SZ_NONE);
            3'b111:  return SZ_HALF;
            default: return SZ_NONE;
        endcase
    endfunction
endpackage

// File: rtl/pkt_fmt_decode.sv
// Turns the format code into a per-slot layout: used flag, size and
// start unit. Starts are the running sum of earlier slot sizes.
// Assumes every legal format fills exactly NUNIT units.
module pkt_fmt_decode
    import pkt_slot_pkg::*;
(
    input  logic [FMT_W-1:0]            fmt,
    output slot_lay_t [NSLOT-1:0]       lay,
    output logic                        legal
);
    // Walk slots in program order, accumulating unit offsets.
    always_comb begin
        logic [POS_W:0] acc;
        slot_sz_e       sz;
        acc = '0;
        for (int k = 0; k < NSLOT; k++) begin
            sz         = fmt_slot_size(fmt, k);
            lay[k].sz  = sz;
            lay[k].used = (sz != SZ_NONE);
            lay[k].pos = acc[POS_W-1:0];
            if (sz != SZ_NONE)
                acc = acc + ((POS_W+1)'(1) << sz);
        end
    end

    // A format is legal when it places at least one slot.
    always_comb legal = (fmt_slot_size(fmt, 0) != SZ_NONE);
endmodule

// File: rtl/pkt_entry_mask.sv
// Applies the branch entry offset: keeps slots starting at or after
// it and flags an offset that lands inside an instruction.
// Assumes layout from pkt_fmt_decode; an illegal format keeps nothing.
module pkt_entry_mask
    import pkt_slot_pkg::*;
(
    input  slot_lay_t [NSLOT-1:0] lay,
    input  logic                  legal,
    input  logic [POS_W-1:0]      entry,
    output logic [NSLOT-1:0]      keep,
    output logic                  misalign
);
    // Compare each start with the offset and look for an exact hit.
    always_comb begin
        logic hit;
        hit = 1'b0;
        for (int k = 0; k < NSLOT; k++) begin
            keep[k] = legal && lay[k].used && (lay[k].pos >= entry);
            if (lay[k].used && (lay[k].pos == entry))
                hit = 1'b1;
        end
        misalign = legal && !hit;
    end
endmodule

// File: rtl/pkt_slot_field.sv
// Extracts one slot's fields from the packet body. The payload is
// right-aligned; a dropped slot drives all fields to zero.
// Assumes pos + units <= NUNIT whenever the slot is used.
module pkt_slot_field
    import pkt_slot_pkg::*;
(
    input  logic [BODY_W-1:0] body,
    input  slot_lay_t         lay,
    input  logic              keep,
    output logic              vld,
    output logic [SZ_W-1:0]   size,
    output logic [POS_W-1:0]  start,
    output logic [BODY_W-1:0] payload
);
    // Shift the slot window down to bit 0 and mask to its length.
    always_comb begin
        int units;
        int shamt;
        units   = lay.used ? (1 << int'(lay.sz)) : 0;
        shamt   = PPU * (NUNIT - int'(lay.pos) - units);
        vld     = keep;
        size    = keep ? SZ_W'(lay.sz) : '0;
        start   = keep ? lay.pos : '0;
        payload = '0;
        if (keep)
            payload = (body >> shamt) & ({BODY_W{1'b1}} >> (BODY_W - PPU * units));
    end
endmodule

// File: rtl/pkt_slot_extract.sv
// Top of the packet slot extractor: decodes the header, masks by
// entry offset, extracts every slot and registers the result.
// Assumes one packet per cycle; synchronous active-low reset.
module pkt_slot_extract
    import pkt_slot_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PKT_W-1:0]        pkt_i,
    input  logic [POS_W-1:0]        entry_i,
    output logic [NSLOT-1:0]        slot_vld_o,
    output logic [SZ_W*NSLOT-1:0]   slot_size_o,
    output logic [POS_W*NSLOT-1:0]  slot_start_o,
    output logic [BODY_W*NSLOT-1:0] slot_payload_o,
    output logic                    par_o,
    output logic                    illegal_o,
    output logic                    misalign_o
);
    slot_lay_t [NSLOT-1:0]   lay;
    logic                    legal;
    logic [NSLOT-1:0]        keep;
    logic                    misalign;
    logic [NSLOT-1:0]        f_vld;
    logic [SZ_W*NSLOT-1:0]   f_size;
    logic [POS_W*NSLOT-1:0]  f_start;
    logic [BODY_W*NSLOT-1:0] f_payload;

    pkt_fmt_decode u_dec (
        .fmt   (pkt_i[PKT_W-1 -: FMT_W]),
        .lay   (lay),
        .legal (legal)
    );

    pkt_entry_mask u_mask (
        .lay      (lay),
        .legal    (legal),
        .entry    (entry_i),
        .keep     (keep),
        .misalign (misalign)
    );

    for (genvar k = 0; k < NSLOT; k++) begin : g_slot
        pkt_slot_field u_fld (
            .body    (pkt_i[BODY_W-1:0]),
            .lay     (lay[k]),
            .keep    (keep[k]),
            .vld     (f_vld[k]),
            .size    (f_size[k*SZ_W +: SZ_W]),
            .start   (f_start[k*POS_W +: POS_W]),
            .payload (f_payload[k*BODY_W +: BODY_W])
        );
    end

    // Output register stage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld_o     <= '0;
            slot_size_o    <= '0;
            slot_start_o   <= '0;
            slot_payload_o <= '0;
            par_o          <= 1'b0;
            illegal_o      <= 1'b0;
            misalign_o     <= 1'b0;
        end else begin
            slot_vld_o     <= f_vld;
            slot_size_o    <= f_size;
            slot_start_o   <= f_start;
            slot_payload_o <= f_payload;
            par_o          <= legal && pkt_i[PKT_W-HDR_W];
            illegal_o      <= !legal;
            misalign_o     <= misalign;
        end
    end
endmodule

// File: rtl/pkt_slot_extract_chk.sv
// Property checker for pkt_slot_extract, attached by bind below.
// Compares registered outputs against inputs of the previous cycle.
module pkt_slot_extract_chk
    import pkt_slot_pkg::*;
(
    input logic                    clk,
    input logic                    rst_n,
    input logic [PKT_W-1:0]        pkt_i,
    input logic [POS_W-1:0]        entry_i,
    input logic [NSLOT-1:0]        slot_vld_o,
    input logic [SZ_W*NSLOT-1:0]   slot_size_o,
    input logic [POS_W*NSLOT-1:0]  slot_start_o,
    input logic [BODY_W*NSLOT-1:0] slot_payload_o,
    input logic                    par_o,
    input logic                    illegal_o,
    input logic                    misalign_o
);
    logic primed;

    // Marks that the outputs reflect a sampled input, not reset.
    always_ff @(posedge clk) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    a_r7_reserved_illegal: assert property (@(posedge clk) disable iff (!rst_n)
        primed && ($past(pkt_i[PKT_W-1 -: FMT_W]) inside {3'b001, 3'b010, 3'b011})
        |-> (illegal_o && slot_vld_o == '0 && !par_o));

    a_r8_parallel_hint: assert property (@(posedge clk) disable iff (!rst_n)
        primed && !illegal_o |-> par_o == $past(pkt_i[PKT_W-HDR_W]));

    a_r10_misalign_excl: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !misalign_o);

    for (genvar k = 0; k < NSLOT; k++) begin : g_chk
        a_r9_entry_mask: assert property (@(posedge clk) disable iff (!rst_n)
            primed && slot_vld_o[k]
            |-> slot_start_o[k*POS_W +: POS_W] >= $past(entry_i));

        a_r11_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !slot_vld_o[k] |-> (slot_size_o[k*SZ_W +: SZ_W] == '0
                && slot_start_o[k*POS_W +: POS_W] == '0
                && slot_payload_o[k*BODY_W +: BODY_W] == '0));
    end
endmodule

bind pkt_slot_extract pkt_slot_extract_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .pkt_i          (pkt_i),
    .entry_i        (entry_i),
    .slot_vld_o     (slot_vld_o),
    .slot_size_o    (slot_size_o),
    .slot_start_o   (slot_start_o),
    .slot_payload_o (slot_payload_o),
    .par_o          (par_o),
    .illegal_o      (illegal_o),
    .misalign_o     (misalign_o)
);

// File: tb/sim_pkt_slot_extract.sv
`timescale 1ns/1ps
module sim_pkt_slot_extract;
    logic         clk = 1'b0;
    logic         rst_n;
    logic [63:0]  pkt;
    logic [1:0]   ent;
    logic [3:0]   slot_vld_o;
    logic [7:0]   slot_size_o;
    logic [7:0]   slot_start_o;
    logic [239:0] slot_payload_o;
    logic         par_o, illegal_o, misalign_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic        e_vld [4];
    logic [1:0]  e_sz  [4];
    logic [1:0]  e_st  [4];
    logic [59:0] e_pl  [4];
    logic        e_ill, e_par, e_mis;

    always #2.5 clk = ~clk;

    pkt_slot_extract u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .pkt_i          (pkt),
        .entry_i        (ent),
        .slot_vld_o     (slot_vld_o),
        .slot_size_o    (slot_size_o),
        .slot_start_o   (slot_start_o),
        .slot_payload_o (slot_payload_o),
        .par_o          (par_o),
        .illegal_o      (illegal_o),
        .misalign_o     (misalign_o)
    );

    task automatic check(input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic string fmt_tag(input logic [2:0] f);
        case (f)
            3'b000:  return "R2";
            3'b100:  return "R3";
            3'b101:  return "R4";
            3'b110:  return "R5";
            3'b111:  return "R6";
            default: return "R7";
        endcase
    endfunction

    // Expected outputs written from the layout requirements.
    task automatic model(input logic [63:0] p, input logic [1:0] e);
        logic [59:0] b;
        int          n;
        int          sz [4];
        int          st [4];
        logic [59:0] pl [4];
        logic        legal, hit;
        b = p[59:0];
        n = 0; legal = 1'b1; hit = 1'b0;
        for (int i = 0; i < 4; i++) begin
            sz[i] = 0; st[i] = 0; pl[i] = '0;
            e_vld[i] = 1'b0; e_sz[i] = '0; e_st[i] = '0; e_pl[i] = '0;
        end
        case (p[63:61])
            3'b000: begin n = 1; sz[0] = 2; st[0] = 0; pl[0] = b; end
            3'b100: begin
                n = 2;
                sz[0] = 1; st[0] = 0; pl[0] = 60'(b[59:30]);
                sz[1] = 1; st[1] = 2; pl[1] = 60'(b[29:0]);
            end
            3'b101: begin
                n = 3;
                sz[0] = 0; st[0] = 0; pl[0] = 60'(b[59:45]);
                sz[1] = 0; st[1] = 1; pl[1] = 60'(b[44:30]);
                sz[2] = 1; st[2] = 2; pl[2] = 60'(b[29:0]);
            end
            3'b110: begin
                n = 3;
                sz[0] = 1; st[0] = 0; pl[0] = 60'(b[59:30]);
                sz[1] = 0; st[1] = 2; pl[1] = 60'(b[29:15]);
                sz[2] = 0; st[2] = 3; pl[2] = 60'(b[14:0]);
            end
            3'b111: begin
                n = 4;
                sz[0] = 0; st[0] = 0; pl[0] = 60'(b[59:45]);
                sz[1] = 0; st[1] = 1; pl[1] = 60'(b[44:30]);
                sz[2] = 0; st[2] = 2; pl[2] = 60'(b[29:15]);
                sz[3] = 0; st[3] = 3; pl[3] = 60'(b[14:0]);
            end
            default: legal = 1'b0;
        endcase
        for (int i = 0; i < n; i++) begin
            if (st[i] == int'(e)) hit = 1'b1;
            if (st[i] >= int'(e)) begin
                e_vld[i] = 1'b1;
                e_sz[i]  = 2'(sz[i]);
                e_st[i]  = 2'(st[i]);
                e_pl[i]  = pl[i];
            end
        end
        e_ill = !legal;
        e_par = legal && p[60];
        e_mis = legal && !hit;
    endtask

    task automatic apply(input logic [63:0] p, input logic [1:0] e);
        string ft;
        @(negedge clk);
        pkt = p; ent = e;
        @(negedge clk);
        model(p, e);
        ft = fmt_tag(p[63:61]);
        check("R7", "illegal", 64'(illegal_o), 64'(e_ill));
        check("R8", "par", 64'(par_o), 64'(e_par));
        check("R10", "misalign", 64'(misalign_o), 64'(e_mis));
        for (int k = 0; k < 4; k++) begin
            string vt, ftag;
            vt   = (e != 2'd0) ? "R9" : ft;
            ftag = e_vld[k] ? ft : "R11";
            check(vt, $sformatf("vld[%0d]", k), 64'(slot_vld_o[k]), 64'(e_vld[k]));
            check(ftag, $sformatf("size[%0d]", k), 64'(slot_size_o[k*2 +: 2]), 64'(e_sz[k]));
            check(ftag, $sformatf("start[%0d]", k), 64'(slot_start_o[k*2 +: 2]), 64'(e_st[k]));
            check(ftag, $sformatf("payload[%0d]", k), 64'(slot_payload_o[k*60 +: 60]), 64'(e_pl[k]));
        end
    endtask

    function automatic logic [63:0] mk(input logic [2:0] f, input logic par,
                                       input logic [59:0] body);
        return {f, par, body};
    endfunction

    initial begin
        logic [59:0] pat;
        void'($urandom(32'd4242));
        pat = 60'hA5C_3E1F_0B7D_9246;
        rst_n = 1'b0;
        pkt = mk(3'b111, 1'b1, pat);
        ent = 2'd0;
        @(negedge clk);
        @(negedge clk);
        // R1: outputs held at zero in reset
        check("R1", "vld in reset", 64'(slot_vld_o), 64'd0);
        check("R1", "payload in reset", slot_payload_o[63:0], 64'd0);
        check("R1", "flags in reset", 64'({par_o, illegal_o, misalign_o}), 64'd0);
        rst_n = 1'b1;

        // Each legal format at offset 0 (R2..R6)
        apply(mk(3'b000, 1'b0, pat), 2'd0);
        apply(mk(3'b100, 1'b1, pat), 2'd0);
        apply(mk(3'b101, 1'b0, ~pat), 2'd0);
        apply(mk(3'b110, 1'b1, pat), 2'd0);
        apply(mk(3'b111, 1'b1, ~pat), 2'd0);
        // Entry offsets (R9, R10)
        for (int e = 1; e < 4; e++) apply(mk(3'b000, 1'b1, pat), 2'(e));
        for (int e = 1; e < 4; e++) apply(mk(3'b100, 1'b0, pat), 2'(e));
        for (int e = 1; e < 4; e++) apply(mk(3'b101, 1'b1, pat), 2'(e));
        for (int e = 1; e < 4; e++) apply(mk(3'b110, 1'b0, pat), 2'(e));
        for (int e = 1; e < 4; e++) apply(mk(3'b111, 1'b1, pat), 2'(e));
        // Reserved codes with hint set and nonzero offset (R7)
        apply(mk(3'b001, 1'b1, pat), 2'd2);
        apply(mk(3'b010, 1'b1, pat), 2'd1);
        apply(mk(3'b011, 1'b1, pat), 2'd3);
        // Random mix
        for (int i = 0; i < 800; i++)
            apply({$urandom, $urandom}, 2'($urandom));

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(5.0 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule